// File: doc/BRIEF.md
# External Register Bus Wait-State Controller

This block connects a DSP core to an external register bus with eight register slots. Slots 0 to 6 sit outside the chip on the bus. Slot 7 is a local register that holds a bank-select field and a set of interrupt status flags. For every access the block decides how long the core must stall. A software-written 14-bit mapping can add exactly one wait state to any external slot, and it does so separately for reads and for writes. An asynchronous wait input from outside logic can hold the access open for longer than that.

The core raises a request along with a slot number, a direction and write data. It keeps all of them steady until the ready output goes high. The ready output is low for every cycle that is inserted. On external slots the block drives read and write strobes, the slot address and the write data onto the bus, and it passes the returned read data back to the core. Accesses to slot 7 never reach the bus and always finish in one cycle. The wait mapping is a single register that is shared by every bank, so software rewrites it after it changes banks.

Top module: `extbus_waitctl`

## Requirements
- R1: After synchronous reset the wait mapping is zero, the bank field is 0, all eight flags are clear, and ready is low while no request is present.
- R2: With no wait state programmed and the wait input low, an access to slots 0 to 6 completes in one cycle: ready is high in the first request cycle.
- R3: The mapping bit at index 2n (bit 2n) adds one wait state to reads of slot n, for n from 0 to 6. That access then takes two cycles, with ready low in the first cycle only.
- R4: The mapping bit at index 2n+1 adds one wait state to writes of slot n only. A read bit has no effect on writes, a write bit has no effect on reads, and a bit belonging to another slot has no effect.
- R5: Accesses to slot 7 take one cycle and assert neither bus strobe, even when every mapping bit is 1 or the wait input is asserted.
- R6: The wait input passes through a two-flop synchronizer and is sampled on the last cycle of the programmed length. While the synchronized value is high, ready stays low. For an input released in cycle k of the access, counting from 0, ready returns in cycle k+2.
- R7: During an external access the read strobe (for reads) or the write strobe (for writes) is high in every cycle of the access. The bus address equals the slot number, and read data from the bus is returned to the core.
- R8: A read of slot 7 returns zeros in bits 15:12, the flags in bits 11:4 and the bank field in bits 3:0. Flag input bits 0 to 7 map to data bits 4 to 11 and stand for A/D finish, SPI, Timer0, Timer1, Timer2, INT0, INT1 and INT2, in that order.
- R9: A write to slot 7 loads the bank field from data bits 3:0 and clears each flag whose data bit (4 to 11) is 1. Data bits 15:12 have no effect.
- R10: A flag that is set in the same cycle as a write-1 clear of that flag remains set.
- R11: Changing the bank field leaves the wait mapping unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the wait mapping register |
| cfg_wdata | input | 14 | New wait mapping (bit 2n read, bit 2n+1 write of slot n) |
| core_req | input | 1 | Access request, held until ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 3 | Register slot number |
| core_wdata | input | 16 | Write data |
| core_rdata | output | 16 | Read data |
| core_ready | output | 1 | Access completes at this clock edge |
| irq_set | input | 8 | One-cycle flag set pulses |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 3 | External slot address |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ext_wait | input | 1 | Asynchronous wait request from outside logic |
| bank_sel | output | 4 | Current bank field |
| irq_flags | output | 8 | Current interrupt status flags |

## Verification
Two things can land on the same clock edge here: a write-1 clear of a status flag in slot 7 and a hardware set pulse for that same flag. The bench drives the set pulse in the exact cycle in which the slot 7 write completes, and the clear mask covers the pulsed flag. A later read of slot 7 must show that flag still set while the other flags named in the mask are cleared. A second overlap is tested too: a held wait input during a wait-mapped access. Here the cycle count must follow the synchronizer delay rather than the programmed single wait state.

// File: rtl/xwc_pkg.sv
package xwc_pkg;
    localparam int DATA_W   = 16;
    localparam int SLOT_W   = 3;
    localparam int NUM_SLOT = 1 << SLOT_W;
    localparam int LOCAL_SLOT = NUM_SLOT - 1;
    localparam int MAP_W    = 2 * (NUM_SLOT - 1);
    localparam int BANK_W   = 4;
    localparam int FLAG_N   = 8;
    localparam int FLAG_LSB = BANK_W;
    localparam int LOCAL_W  = FLAG_LSB + FLAG_N;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_STRETCH
    } seq_state_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [SLOT_W-1:0] slot;
    } xfer_t;

    function automatic logic is_local(input logic [SLOT_W-1:0] slot);
        return slot == SLOT_W'(LOCAL_SLOT);
    endfunction

    function automatic logic slot_waits(input logic [MAP_W-1:0] map,
                                        input logic [SLOT_W-1:0] slot,
                                        input logic we);
        logic [SLOT_W:0] idx;
        idx = {slot, we};
        if (is_local(slot))
            return 1'b0;
        return map[idx];
    endfunction
endpackage

// File: rtl/xwc_sync.sv
module xwc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/xwc_seq.sv
module xwc_seq
    import xwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  xfer_t            xfer,
    input  logic [MAP_W-1:0] map,
    input  logic             wait_s,
    output logic             ready
);
    seq_state_e state, state_nx;

    always_comb begin
        ready    = 1'b0;
        state_nx = state;
        unique case (state)
            SEQ_IDLE: begin
                if (xfer.req) begin
                    if (is_local(xfer.slot)) begin
                        ready = 1'b1;
                    end else if (slot_waits(map, xfer.slot, xfer.we)) begin
                        state_nx = SEQ_STRETCH;
                    end else begin
                        ready = !wait_s;
                        if (wait_s)
                            state_nx = SEQ_STRETCH;
                    end
                end
            end
            SEQ_STRETCH: begin
                ready = !wait_s;
                if (!wait_s)
                    state_nx = SEQ_IDLE;
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= SEQ_IDLE;
        else
            state <= state_nx;
    end

    // R3
    stretch_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_STRETCH) |-> $past(xfer.req));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer.req && !ready) |=> (xfer.req && $stable(xfer.slot) && $stable(xfer.we)));
endmodule

// File: rtl/xwc_local.sv
module xwc_local
    import xwc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [LOCAL_W-1:0] wdata,
    input  logic [FLAG_N-1:0]  irq_set,
    output logic [BANK_W-1:0]  bank,
    output logic [FLAG_N-1:0]  flags
);
    logic [FLAG_N-1:0] clr_mask;

    assign clr_mask = wr ? wdata[FLAG_LSB +: FLAG_N] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank  <= '0;
            flags <= '0;
        end else begin
            if (wr)
                bank <= wdata[BANK_W-1:0];
            flags <= (flags & ~clr_mask) | irq_set;
        end
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_set != '0) |=> ((flags & $past(irq_set)) == $past(irq_set)));

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && irq_set == '0) |=> ((flags & $past(wdata[FLAG_LSB +: FLAG_N])) == '0));
endmodule

// File: rtl/extbus_waitctl.sv
module extbus_waitctl
    import xwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MAP_W-1:0]  cfg_wdata,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [SLOT_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_ready,
    input  logic [FLAG_N-1:0] irq_set,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [SLOT_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_wait,
    output logic [BANK_W-1:0] bank_sel,
    output logic [FLAG_N-1:0] irq_flags
);
    logic [MAP_W-1:0] wait_map;
    logic             wait_s;
    logic             local_hit;
    logic             local_wr;
    xfer_t            xfer;

    always_ff @(posedge clk) begin
        if (rst)
            wait_map <= '0;
        else if (cfg_we)
            wait_map <= cfg_wdata;
    end

    assign xfer      = '{req: core_req, we: core_we, slot: core_addr};
    assign local_hit = is_local(core_addr);
    assign local_wr  = core_req && core_we && local_hit;

    xwc_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_wait),
        .sync_out (wait_s)
    );

    xwc_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .xfer   (xfer),
        .map    (wait_map),
        .wait_s (wait_s),
        .ready  (core_ready)
    );

    xwc_local u_local (
        .clk     (clk),
        .rst     (rst),
        .wr      (local_wr),
        .wdata   (core_wdata[LOCAL_W-1:0]),
        .irq_set (irq_set),
        .bank    (bank_sel),
        .flags   (irq_flags)
    );

    assign ext_rd    = core_req && !core_we && !local_hit;
    assign ext_wr    = core_req &&  core_we && !local_hit;
    assign ext_addr  = core_addr;
    assign ext_wdata = core_wdata;

    always_comb begin
        if (local_hit)
            core_rdata = {{(DATA_W-LOCAL_W){1'b0}}, irq_flags, bank_sel};
        else
            core_rdata = ext_rdata;
    end

    // R5
    local_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (core_req && local_hit) |-> (core_ready && !ext_rd && !ext_wr));

    // R11
    map_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(wait_map));

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !local_wr |=> $stable(bank_sel));
endmodule

// File: tb/extbus_waitctl_bench.sv
module extbus_waitctl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_wdata = '0;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic [2:0]  core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_rdata;
    logic        core_ready;
    logic [7:0]  irq_set = '0;
    logic        ext_rd, ext_wr;
    logic [2:0]  ext_addr;
    logic [15:0] ext_wdata;
    logic [15:0] ext_rdata;
    logic        ext_wait = 1'b0;
    logic [3:0]  bank_sel;
    logic [7:0]  irq_flags;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_cnt  = 0;
    int wr_cnt  = 0;

    always #10 clk = ~clk;

    assign ext_rdata = 16'hC0D0 | {13'd0, ext_addr};

    always @(posedge clk) begin
        if (ext_rd) rd_cnt <= rd_cnt + 1;
        if (ext_wr) wr_cnt <= wr_cnt + 1;
    end

    extbus_waitctl u_extbus_waitctl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ready(core_ready),
        .irq_set(irq_set), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_wait(ext_wait),
        .bank_sel(bank_sel), .irq_flags(irq_flags)
    );

    // {map[13:0], we, slot[2:0], expected cycles[3:0]}
    localparam int NVEC = 10;
    localparam logic [21:0] VEC [NVEC] = '{
        {14'h0000, 1'b0, 3'd0, 4'd1},  // R2
        {14'h0001, 1'b0, 3'd0, 4'd2},  // R3
        {14'h0001, 1'b1, 3'd0, 4'd1},  // R4
        {14'h0002, 1'b1, 3'd0, 4'd2},  // R4
        {14'h0002, 1'b0, 3'd0, 4'd1},  // R4
        {14'h2000, 1'b1, 3'd6, 4'd2},  // R4
        {14'h1000, 1'b0, 3'd6, 4'd2},  // R3
        {14'h3FFF, 1'b0, 3'd7, 4'd1},  // R5
        {14'h3FFF, 1'b1, 3'd3, 4'd2},  // R4
        {14'h0400, 1'b0, 3'd4, 4'd1}   // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_map(input logic [13:0] m);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic we, input logic [2:0] slot, input logic [15:0] wd,
                          input int release_at, input logic [7:0] pulse,
                          output int cyc, output logic [15:0] rd);
        int c;
        c = 0;
        rd = '0;
        @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        core_req = 1'b1;
        core_we = we;
        core_addr = slot;
        core_wdata = wd;
        irq_set = pulse;
        forever begin
            if (c == release_at) ext_wait = 1'b0;
            #1;
            if (core_ready) begin
                rd = core_rdata;
                break;
            end
            @(negedge clk);
            irq_set = '0;
            c++;
            if (c > 40) break;
        end
        @(negedge clk);
        core_req = 1'b0;
        irq_set = '0;
        cyc = c + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] rd;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        #1;
        check("R1 ready idle", {31'd0, core_ready}, 32'd0);
        check("R1 bank/flags", {20'd0, irq_flags, bank_sel}, 32'd0);
        access(1'b0, 3'd7, 16'h0, -1, 8'h00, cyc, rd);
        check("R1 local read", {16'd0, rd}, 32'd0);
        access(1'b0, 3'd2, 16'h0, -1, 8'h00, cyc, rd);
        check("R1 map zero", cyc, 1);

        for (int v = 0; v < NVEC; v++) begin
            logic [21:0] e;
            e = VEC[v];
            set_map(e[21:8]);
            access(e[7], e[6:4], 16'h1234, -1, 8'h00, cyc, rd);
            check("R3/R4 cycles", cyc, {28'd0, e[3:0]});
            if (e[6:4] == 3'd7) begin
                check("R5 no strobe", rd_cnt + wr_cnt, 0);
            end else if (e[7]) begin
                check("R7 wr strobe", wr_cnt, {28'd0, e[3:0]});
                check("R7 no rd", rd_cnt, 0);
            end else begin
                check("R7 rd strobe", rd_cnt, {28'd0, e[3:0]});
                check("R7 rdata", {16'd0, rd}, {16'd0, 16'hC0D0 | {13'd0, e[6:4]}});
            end
        end

        // R6 wait on unmapped access: released in cycle 3 -> ready in cycle 5
        set_map(14'h0000);
        ext_wait = 1'b1;
        idle(3);
        access(1'b0, 3'd2, 16'h0, 3, 8'h00, cyc, rd);
        check("R6 stretch no map", cyc, 6);
        // R6 wait on a mapped access
        set_map(14'h0010);
        ext_wait = 1'b1;
        idle(3);
        access(1'b0, 3'd2, 16'h0, 3, 8'h00, cyc, rd);
        check("R6 stretch mapped", cyc, 6);
        // R5 local slot ignores wait
        set_map(14'h3FFF);
        ext_wait = 1'b1;
        idle(3);
        access(1'b1, 3'd7, 16'h0000, -1, 8'h00, cyc, rd);
        check("R5 local with wait", cyc, 1);
        check("R5 local no strobe", rd_cnt + wr_cnt, 0);
        ext_wait = 1'b0;
        idle(3);

        // R8 flag order and layout: A/D (bit0) and INT2 (bit7)
        @(negedge clk);
        irq_set = 8'h81;
        @(negedge clk);
        irq_set = 8'h00;
        access(1'b0, 3'd7, 16'h0, -1, 8'h00, cyc, rd);
        check("R8 layout", {16'd0, rd}, 32'h0810);
        // R9 write bank 5, clear A/D only
        access(1'b1, 3'd7, 16'h0015, -1, 8'h00, cyc, rd);
        access(1'b0, 3'd7, 16'h0, -1, 8'h00, cyc, rd);
        check("R9 w1c/bank", {16'd0, rd}, 32'h0805);
        // R10 set SPI while clearing all flags in the same cycle
        access(1'b1, 3'd7, 16'h0FF0, -1, 8'h02, cyc, rd);
        access(1'b0, 3'd7, 16'h0, -1, 8'h00, cyc, rd);
        check("R10 set wins", {16'd0, rd}, 32'h0020);
        // R9 upper bits ignored, R8 read zero
        access(1'b1, 3'd7, 16'hF003, -1, 8'h00, cyc, rd);
        access(1'b0, 3'd7, 16'h0, -1, 8'h00, cyc, rd);
        check("R9 upper ignored", {16'd0, rd}, 32'h0023);

        // R11 bank change keeps mapping
        set_map(14'h0004);
        access(1'b1, 3'd7, 16'h0009, -1, 8'h00, cyc, rd);
        check("R11 bank out", {28'd0, bank_sel}, 32'd9);
        access(1'b0, 3'd1, 16'h0, -1, 8'h00, cyc, rd);
        check("R11 map kept", cyc, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule